// File: doc/BRIEF.md
# Expansion-Card Static RAM Bridge

This block connects a 16-bit expansion bus to a byte-wide 2 KB static RAM on the card. The RAM fills the lower half of the card's 4 K-word space. The upper half is handed to other on-card logic through a separate active-low select. The bridge samples the bus controls on a local clock. From them it sequences the RAM's active-low chip, output and write enables. It also drives the direction and enable of the transceiver that joins the bus to the card's internal data path.

The bus read/write level sets the transceiver direction once the card is selected, before either strobe arrives. The path is therefore settled before data moves. A transfer to the RAM runs in a fixed order:

1. Chip enable asserts when the card is selected in the RAM half.
2. Output enable (for a read) or write enable (for a write) follows once a strobe matching the read/write level is seen.
3. The RAM commits a written byte when write enable rises.
4. Chip enable drops together with that edge. It stays high until the card select is released.

Read data is captured from the RAM and returned on the low byte lane, with the upper lane held at zero. All of this happens while the read strobe is still low.

Top module: `card_sram_bridge`

## Requirements
- R1: During and after reset, ram_ce_n, ram_oe_n, ram_we_n, xcvr_en_n and aux_sel_n are 1, and bus_rdata is 0.
- R2: ram_ce_n goes to 0 on the first clock edge that samples bus_sel_n = 0 with bus_addr bit 11 = 0. It never goes to 0 otherwise.
- R3: With bus_sel_n = 0 and bus_addr bit 11 = 1, aux_sel_n is 0 one edge later. In that case ram_ce_n, ram_oe_n and ram_we_n stay 1, and a write there leaves RAM contents unchanged.
- R4: ram_oe_n goes to 0 only on an edge after ram_ce_n is already 0. This happens when bus_rd_n = 0 and bus_rw = 1 are sampled.
- R5: ram_we_n goes to 0 only on an edge after ram_ce_n is already 0, with bus_wr_n = 0 and bus_rw = 0 sampled. The byte on bus_wdata is stored at ram_addr when ram_we_n rises.
- R6: ram_oe_n and ram_we_n are never 0 together. ram_we_n stays 1 whenever bus_rw was sampled 1, even with bus_wr_n = 0.
- R7: xcvr_dir equals the bus_rw level from the previous edge (1 = toward the bus). xcvr_en_n is 0 only after an edge that sampled bus_sel_n = 0 in the RAM half.
- R8: ram_addr equals bus_addr bits 10:0, captured when the card is selected, and held for the whole transfer.
- R9: After output enable asserts, bus_rdata holds the RAM byte in bits 7:0 and zero in bits 15:8, while bus_rd_n is still 0.
- R10: ram_ce_n (with ram_oe_n or ram_we_n) returns to 1 on the edge that samples both strobes high after an access. It stays 1 until bus_sel_n has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel_n | input | 1 | Card select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rw | input | 1 | Transfer direction, 1 = read |
| bus_addr | input | 12 | Word address within card space |
| bus_wdata | input | 8 | Write data, low byte lane |
| bus_rdata | output | 16 | Read data to the bus |
| ram_addr | output | 11 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward bus |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| aux_sel_n | output | 1 | Upper-half select for other logic, active low |

## Verification
Every control output is a register. It therefore reflects the inputs sampled at the first rising edge after a stimulus. The exception is bus_rdata, which trails output enable by one further edge. The bench changes inputs on falling edges and checks on the next falling edge. Each step of a transfer (select, strobe, release) is checked exactly one edge later, and read data two edges after the strobe. Stored bytes are confirmed by reading them back through a behavioural RAM model that commits on the rising write enable.

// File: rtl/csb_pkg.sv
package csb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_RD    = 3'd2,
      ST_WR    = 3'd3,
      ST_DONE  = 3'd4
   } csb_state_e;
endpackage

// File: rtl/csb_decode.sv
module csb_decode (
   input  logic bus_sel_n,
   input  logic addr_top,
   output logic ram_hit,
   output logic aux_hit
);
   always_comb begin
      ram_hit = !bus_sel_n && !addr_top;
      aux_hit = !bus_sel_n && addr_top;
   end
endmodule

// File: rtl/csb_seq.sv
module csb_seq
   import csb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ram_hit,
   input  logic       bus_sel_n,
   input  logic       bus_rd_n,
   input  logic       bus_wr_n,
   input  logic       bus_rw,
   output csb_state_e st,
   output logic       ce_n,
   output logic       oe_n,
   output logic       we_n
);
   csb_state_e nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE:  if (ram_hit) nxt = ST_ARMED;
         ST_ARMED: begin
            if (!ram_hit)                nxt = ST_IDLE;
            else if (!bus_rd_n && bus_rw)  nxt = ST_RD;
            else if (!bus_wr_n && !bus_rw) nxt = ST_WR;
         end
         ST_RD: begin
            if (bus_sel_n)                 nxt = ST_IDLE;
            else if (bus_rd_n && bus_wr_n) nxt = ST_DONE;
         end
         ST_WR: begin
            if (bus_sel_n)                           nxt = ST_IDLE;
            else if ((bus_rd_n && bus_wr_n) || bus_rw) nxt = ST_DONE;
         end
         ST_DONE:  if (bus_sel_n) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         ce_n <= 1'b1;
         oe_n <= 1'b1;
         we_n <= 1'b1;
      end else begin
         st   <= nxt;
         ce_n <= !(nxt == ST_ARMED || nxt == ST_RD || nxt == ST_WR);
         oe_n <= (nxt != ST_RD);
         we_n <= (nxt != ST_WR);
      end
   end
endmodule

// File: rtl/csb_path.sv
module csb_path
   import csb_pkg::*;
#(
   parameter int RAM_AW = 11,
   parameter int DATA_W = 8,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  csb_state_e        st,
   input  logic              ram_hit,
   input  logic              aux_hit,
   input  logic              bus_wr_n,
   input  logic              bus_rw,
   input  logic [RAM_AW-1:0] bus_addr_lo,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              xcvr_dir,
   output logic              xcvr_en_n,
   output logic              aux_sel_n
);
   localparam int PAD_W = BUS_W - DATA_W;

   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_addr  <= '0;
         ram_wdata <= '0;
         rdata_q   <= '0;
         xcvr_dir  <= 1'b0;
         xcvr_en_n <= 1'b1;
         aux_sel_n <= 1'b1;
      end else begin
         if (st == ST_IDLE && ram_hit)
            ram_addr <= bus_addr_lo;
         if (ram_hit && !bus_wr_n && !bus_rw)
            ram_wdata <= bus_wdata;
         if (st == ST_RD)
            rdata_q <= ram_rdata;
         xcvr_dir  <= bus_rw;
         xcvr_en_n <= !ram_hit;
         aux_sel_n <= !aux_hit;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign bus_rdata = {{PAD_W{1'b0}}, rdata_q};
      end else begin : g_flat
         assign bus_rdata = rdata_q;
      end
   endgenerate
endmodule

// File: rtl/card_sram_bridge.sv
module card_sram_bridge
   import csb_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic              bus_rw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [ADDR_W-2:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_ce_n,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic              xcvr_dir,
   output logic              xcvr_en_n,
   output logic              aux_sel_n
);
   localparam int RAM_AW = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("card_sram_bridge: ADDR_W must be at least 2");
      end
      if (DATA_W > BUS_W) begin : g_bad_data
         $error("card_sram_bridge: DATA_W must not exceed BUS_W");
      end
   endgenerate

   logic       ram_hit;
   logic       aux_hit;
   csb_state_e st;

   csb_decode u_dec (
      .bus_sel_n (bus_sel_n),
      .addr_top  (bus_addr[ADDR_W-1]),
      .ram_hit   (ram_hit),
      .aux_hit   (aux_hit)
   );

   csb_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ram_hit   (ram_hit),
      .bus_sel_n (bus_sel_n),
      .bus_rd_n  (bus_rd_n),
      .bus_wr_n  (bus_wr_n),
      .bus_rw    (bus_rw),
      .st        (st),
      .ce_n      (ram_ce_n),
      .oe_n      (ram_oe_n),
      .we_n      (ram_we_n)
   );

   csb_path #(
      .RAM_AW (RAM_AW),
      .DATA_W (DATA_W),
      .BUS_W  (BUS_W)
   ) u_path (
      .clk         (clk),
      .rst_n       (rst_n),
      .st          (st),
      .ram_hit     (ram_hit),
      .aux_hit     (aux_hit),
      .bus_wr_n    (bus_wr_n),
      .bus_rw      (bus_rw),
      .bus_addr_lo (bus_addr[RAM_AW-1:0]),
      .bus_wdata   (bus_wdata),
      .ram_rdata   (ram_rdata),
      .ram_addr    (ram_addr),
      .ram_wdata   (ram_wdata),
      .bus_rdata   (bus_rdata),
      .xcvr_dir    (xcvr_dir),
      .xcvr_en_n   (xcvr_en_n),
      .aux_sel_n   (aux_sel_n)
   );
endmodule

// File: rtl/csb_chk.sv
module csb_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_sel_n,
   input logic bus_rd_n,
   input logic bus_wr_n,
   input logic bus_rw,
   input logic addr_top,
   input logic ram_ce_n,
   input logic ram_oe_n,
   input logic ram_we_n,
   input logic xcvr_en_n,
   input logic aux_sel_n
);
   // R2
   ce_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_ce_n) |-> ($past(!bus_sel_n) && !$past(addr_top)));

   // R3
   aux_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_sel_n |-> ($past(addr_top) && $past(!bus_sel_n)));

   // R4
   oe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_oe_n) |-> ($past(!ram_ce_n) && $past(bus_rw)));

   // R5
   we_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> ($past(!ram_ce_n) && $past(!bus_wr_n)));

   // R6
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_oe_n && !ram_we_n));

   // R6
   we_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> !$past(bus_rw));

   // R7
   xcvr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xcvr_en_n |-> ($past(!bus_sel_n) && !$past(addr_top)));

   // R10
   ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!ram_oe_n || !ram_we_n) && bus_rd_n && bus_wr_n) |=> ram_ce_n);
endmodule

bind card_sram_bridge csb_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel_n (bus_sel_n),
   .bus_rd_n  (bus_rd_n),
   .bus_wr_n  (bus_wr_n),
   .bus_rw    (bus_rw),
   .addr_top  (bus_addr[ADDR_W-1]),
   .ram_ce_n  (ram_ce_n),
   .ram_oe_n  (ram_oe_n),
   .ram_we_n  (ram_we_n),
   .xcvr_en_n (xcvr_en_n),
   .aux_sel_n (aux_sel_n)
);

// File: tb/card_sram_bridge_tb.sv
module card_sram_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel_n = 1'b1;
   logic        bus_rd_n = 1'b1;
   logic        bus_wr_n = 1'b1;
   logic        bus_rw = 1'b1;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [10:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata;
   logic        ram_ce_n, ram_oe_n, ram_we_n;
   logic        xcvr_dir, xcvr_en_n, aux_sel_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] mem [0:2047];

   always #4 clk = ~clk;

   card_sram_bridge u_dut (
      .clk (clk), .rst_n (rst_n),
      .bus_sel_n (bus_sel_n), .bus_rd_n (bus_rd_n), .bus_wr_n (bus_wr_n),
      .bus_rw (bus_rw), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .ram_addr (ram_addr), .ram_wdata (ram_wdata),
      .ram_rdata (ram_rdata), .ram_ce_n (ram_ce_n), .ram_oe_n (ram_oe_n),
      .ram_we_n (ram_we_n), .xcvr_dir (xcvr_dir), .xcvr_en_n (xcvr_en_n),
      .aux_sel_n (aux_sel_n)
   );

   // behavioural static RAM
   assign ram_rdata = (!ram_ce_n && !ram_oe_n) ? mem[ram_addr] : 8'hzz;
   always @(posedge ram_we_n) mem[ram_addr] = ram_wdata;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 ce_n", ram_ce_n, 1);
      chk("R1 oe_n", ram_oe_n, 1);
      chk("R1 we_n", ram_we_n, 1);
      chk("R1 xcvr_en_n", xcvr_en_n, 1);
      chk("R1 aux_sel_n", aux_sel_n, 1);
      chk("R1 bus_rdata", bus_rdata, 0);
   endtask

   task automatic t_write(input logic [11:0] a, input logic [7:0] d);
      bus_sel_n = 0; bus_rw = 0; bus_addr = a; bus_wdata = d;
      tick();
      chk("R2 ce_n on select", ram_ce_n, 0);
      chk("R5 we_n before strobe", ram_we_n, 1);
      chk("R7 dir write", xcvr_dir, 0);
      chk("R7 en_n", xcvr_en_n, 0);
      chk("R8 ram_addr", ram_addr, {21'd0, a[10:0]});
      bus_wr_n = 0;
      tick();
      chk("R5 we_n low", ram_we_n, 0);
      chk("R6 oe_n high in write", ram_oe_n, 1);
      bus_wr_n = 1;
      tick();
      chk("R10 ce_n release", ram_ce_n, 1);
      chk("R5 we_n release", ram_we_n, 1);
      chk("R5 stored byte", mem[a[10:0]], d);
      bus_sel_n = 1; bus_rw = 1;
      tick();
   endtask

   task automatic t_read(input logic [11:0] a, input logic [7:0] expd);
      bus_sel_n = 0; bus_rw = 1; bus_addr = a;
      tick();
      chk("R4 ce_n first", ram_ce_n, 0);
      chk("R4 oe_n not yet", ram_oe_n, 1);
      chk("R7 dir read", xcvr_dir, 1);
      bus_rd_n = 0;
      tick();
      chk("R4 oe_n low", ram_oe_n, 0);
      chk("R6 we_n high in read", ram_we_n, 1);
      tick();
      chk("R9 bus_rdata", bus_rdata, {16'd0, 8'h00, expd});
      chk("R8 ram_addr held", ram_addr, {21'd0, a[10:0]});
      bus_rd_n = 1;
      tick();
      chk("R10 ce_n release", ram_ce_n, 1);
      chk("R10 oe_n release", ram_oe_n, 1);
      tick();
      chk("R10 ce_n stays high", ram_ce_n, 1);
      bus_sel_n = 1;
      tick();
   endtask

   task automatic t_aux(input logic [11:0] a, input logic [7:0] d);
      bus_sel_n = 0; bus_rw = 0; bus_addr = a; bus_wdata = d;
      tick();
      chk("R3 aux_sel_n", aux_sel_n, 0);
      chk("R3 ce_n idle", ram_ce_n, 1);
      chk("R7 en_n off in aux", xcvr_en_n, 1);
      bus_wr_n = 0;
      tick();
      chk("R3 we_n idle", ram_we_n, 1);
      bus_wr_n = 1; bus_sel_n = 1; bus_rw = 1;
      tick();
      chk("R3 aux_sel_n release", aux_sel_n, 1);
   endtask

   task automatic t_dir_mismatch(input logic [11:0] a);
      bus_sel_n = 0; bus_rw = 1; bus_addr = a; bus_wdata = 8'hEE;
      tick();
      bus_wr_n = 0;
      tick();
      chk("R6 we_n suppressed", ram_we_n, 1);
      chk("R6 ce_n held", ram_ce_n, 0);
      bus_wr_n = 1; bus_sel_n = 1;
      tick();
      tick();
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = i[7:0] ^ 8'h5A;
      repeat (3) tick();
      t_reset();
      rst_n = 1;
      tick();
      t_reset();
      t_read(12'h010, 8'h10 ^ 8'h5A);
      t_write(12'h005, 8'hA5);
      t_read(12'h005, 8'hA5);
      t_write(12'h7FF, 8'h3C);
      t_read(12'h7FF, 8'h3C);
      t_aux(12'h805, 8'h77);
      t_read(12'h005, 8'hA5);
      t_dir_mismatch(12'h006);
      t_read(12'h006, 8'h06 ^ 8'h5A);
      t_write(12'h000, 8'h00);
      t_read(12'h000, 8'h00);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule